// File: doc/BRIEF.md
# Shared Resource Ownership Lock Bank

A bank of per-requester ownership registers that settles which of several independent software agents holds each of a set of shared resources. Every requester has a 32-bit register in which each bit stands for one resource. A requester asks for resources by writing a mask to its "take" word and gives them up by writing a mask to its "give" word. A take succeeds bit by bit, and only for resources that no other requester holds at that moment. Software then reads its register back to learn which bits it was granted.

Misuse raises a sticky error flag. Misuse means asking for a resource the requester already holds, or giving up one it does not hold. The flag drives an interrupt line through an enable bit. The flag stays set until software writes a 1 to the flag's clear register. The bus takes one access per clock. A read strobe returns data on the following cycle.

Top module: `res_lock_bank`

## Requirements
- R1: After synchronous reset, every ownership register reads 0, the error flag reads 0, the enable reads 0 and `irq_o` is low.
- R2: A write to a requester's take word (its base + 4) sets that requester's bit n for every bit n that is 1 in the write data and that no other requester holds.
- R3: A take request for a bit that another requester holds leaves that bit 0 in the writer's register and unchanged in the holder's. At no time do two requesters hold the same bit.
- R4: A write to a requester's give word (its base + 0) clears every bit that is 1 in the write data and leaves all other bits unchanged.
- R5: A read of either word of a requester returns that requester's current ownership bits on `rd_data_o` in the cycle after `rd_en_i`.
- R6: A take write that names a bit the writer already holds sets the error flag. Its grantable bits are still granted.
- R7: A give write that names a bit the writer does not hold sets the error flag.
- R8: The error flag (bit 0 at 0x300) stays set until a write with data bit 0 equal to 1 to 0x300. `irq_o` equals the flag AND the enable, which is bit 0 at 0x304 (read/write).
- R9: Requesters 0 to 5 have their base at 0x100 + 8·i. Requesters 6 to 15 have their base at 0x200 + 8·(i−6).
- R10: A read of an address that maps to nothing returns 0. A write to such an address changes no register.
- R11: When two requesters ask for the same free bit in back-to-back writes, the first write wins. The second requester gets 0 for that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 16 | Byte address |
| wr_data_i | input | 32 | Write data / mask |
| rd_data_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| irq_o | output | 1 | Error interrupt (flag AND enable) |

## Verification
The take path is tested in three situations: masks whose bits are all free, masks that overlap bits held by another requester, and masks that overlap the writer's own bits. These separate a plain grant, a blocked grant and a misuse report. Give masks that are partly outside the writer's holdings show that clearing works bit by bit and that the misuse check is independent of it. Back-to-back takes of one free bit by two requesters check arrival order. Requesters at the edges of both address windows, together with holes between the windows, check the decode.

// File: rtl/lb_pkg.sv
package lb_pkg;

    localparam int LB_IDX_W = 8;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_OWN    = 2'd1,
        ACC_IRQ_FL = 2'd2,
        ACC_IRQ_EN = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e           kind;
        logic                take;
        logic [LB_IDX_W-1:0] idx;
    } acc_dec_t;

    function automatic int word_base(input int i, input int lo_cnt,
                                     input int base_lo, input int base_hi);
        if (i < lo_cnt)
            return base_lo + i * 8;
        else
            return base_hi + (i - lo_cnt) * 8;
    endfunction

endpackage

// File: rtl/lb_decode.sv
module lb_decode
    import lb_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int NUM_REQ = 16,
    parameter int LO_CNT  = 6,
    parameter int BASE_LO = 'h100,
    parameter int BASE_HI = 'h200,
    parameter int FL_ADDR = 'h300,
    parameter int EN_ADDR = 'h304
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_dec_t          dec
);
    always_comb begin
        dec = '{kind: ACC_NONE, take: 1'b0, idx: '0};
        if (int'(addr) == FL_ADDR)
            dec.kind = ACC_IRQ_FL;
        else if (int'(addr) == EN_ADDR)
            dec.kind = ACC_IRQ_EN;
        for (int i = 0; i < NUM_REQ; i++) begin
            int b;
            b = word_base(i, LO_CNT, BASE_LO, BASE_HI);
            if (int'(addr) == b || int'(addr) == b + 4) begin
                dec.kind = ACC_OWN;
                dec.take = (int'(addr) == b + 4);
                dec.idx  = LB_IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lb_own_regs.sv
module lb_own_regs
    import lb_pkg::*;
#(
    parameter int NUM_REQ = 16,
    parameter int NUM_RES = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       do_take,
    input  logic                       do_give,
    input  logic [LB_IDX_W-1:0]        idx,
    input  logic [NUM_RES-1:0]         mask,
    output logic [NUM_REQ*NUM_RES-1:0] own_flat,
    output logic [NUM_RES-1:0]         own_sel,
    output logic                       misuse
);
    logic [NUM_RES-1:0] row_q [NUM_REQ];
    logic [NUM_RES-1:0] others;

    always_comb begin
        others  = '0;
        own_sel = '0;
        for (int j = 0; j < NUM_REQ; j++) begin
            if (j == int'(idx))
                own_sel = row_q[j];
            else
                others = others | row_q[j];
        end
    end

    assign misuse = (do_take && |(mask & own_sel)) ||
                    (do_give && |(mask & ~own_sel));

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst)
                row_q[g] <= '0;
            else if (int'(idx) == g) begin
                if (do_take)
                    row_q[g] <= row_q[g] | (mask & ~others);
                else if (do_give)
                    row_q[g] <= row_q[g] & ~mask;
            end
        end
        assign own_flat[g*NUM_RES +: NUM_RES] = row_q[g];
    end
endmodule

// File: rtl/lb_irq.sv
module lb_irq (
    input  logic clk,
    input  logic rst,
    input  logic misuse,
    input  logic fl_clr,
    input  logic en_wr,
    input  logic en_val,
    output logic flag_q,
    output logic en_q,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            if (misuse)
                flag_q <= 1'b1;
            else if (fl_clr)
                flag_q <= 1'b0;
            if (en_wr)
                en_q <= en_val;
        end
    end
    assign irq = flag_q & en_q;
endmodule

// File: rtl/res_lock_bank.sv
module res_lock_bank
    import lb_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int NUM_REQ = 16,
    parameter int LO_CNT  = 6,
    parameter int BASE_LO = 'h100,
    parameter int BASE_HI = 'h200,
    parameter int FL_ADDR = 'h300,
    parameter int EN_ADDR = 'h304
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    localparam int NUM_RES = DATA_W;

    acc_dec_t                   dec;
    logic                       wr_take, wr_give, map_hit;
    logic                       misuse, flag_q, en_q, fl_clr, en_wr;
    logic [NUM_REQ*NUM_RES-1:0] own_flat;
    logic [NUM_RES-1:0]         own_sel;
    logic [DATA_W-1:0]          rd_next;

    lb_decode #(
        .ADDR_W(ADDR_W), .NUM_REQ(NUM_REQ), .LO_CNT(LO_CNT),
        .BASE_LO(BASE_LO), .BASE_HI(BASE_HI),
        .FL_ADDR(FL_ADDR), .EN_ADDR(EN_ADDR)
    ) u_dec (
        .addr(addr_i),
        .dec (dec)
    );

    assign map_hit = (dec.kind != ACC_NONE);
    assign wr_take = wr_en_i && dec.kind == ACC_OWN && dec.take;
    assign wr_give = wr_en_i && dec.kind == ACC_OWN && !dec.take;
    assign fl_clr  = wr_en_i && dec.kind == ACC_IRQ_FL && wr_data_i[0];
    assign en_wr   = wr_en_i && dec.kind == ACC_IRQ_EN;

    lb_own_regs #(.NUM_REQ(NUM_REQ), .NUM_RES(NUM_RES)) u_own (
        .clk     (clk),
        .rst     (rst),
        .do_take (wr_take),
        .do_give (wr_give),
        .idx     (dec.idx),
        .mask    (wr_data_i),
        .own_flat(own_flat),
        .own_sel (own_sel),
        .misuse  (misuse)
    );

    lb_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .misuse(misuse),
        .fl_clr(fl_clr),
        .en_wr (en_wr),
        .en_val(wr_data_i[0]),
        .flag_q(flag_q),
        .en_q  (en_q),
        .irq   (irq_o)
    );

    always_comb begin
        unique case (dec.kind)
            ACC_OWN:    rd_next = own_sel;
            ACC_IRQ_FL: rd_next = {{(DATA_W-1){1'b0}}, flag_q};
            ACC_IRQ_EN: rd_next = {{(DATA_W-1){1'b0}}, en_q};
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data_o <= '0;
        else if (rd_en_i)
            rd_data_o <= rd_next;
    end
endmodule

// File: rtl/lb_checker.sv
module lb_checker #(
    parameter int NUM_REQ = 16,
    parameter int NUM_RES = 32,
    parameter int IDX_W   = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_REQ*NUM_RES-1:0] own_flat,
    input logic                       wr_take,
    input logic                       wr_give,
    input logic                       fl_clr,
    input logic                       rd_en_i,
    input logic                       map_hit,
    input logic [IDX_W-1:0]           idx,
    input logic [NUM_RES-1:0]         wr_data_i,
    input logic [NUM_RES-1:0]         rd_data_o,
    input logic                       flag_q,
    input logic                       irq_o
);
    function automatic logic [NUM_RES-1:0] row_of(
        input logic [NUM_REQ*NUM_RES-1:0] f, input logic [IDX_W-1:0] k);
        logic [NUM_RES-1:0] r;
        r = '0;
        for (int j = 0; j < NUM_REQ; j++)
            if (j == int'(k)) r = f[j*NUM_RES +: NUM_RES];
        return r;
    endfunction

    for (genvar b = 0; b < NUM_RES; b++) begin : g_col
        logic [NUM_REQ-1:0] col;
        for (genvar r = 0; r < NUM_REQ; r++) begin : g_bit
            assign col[r] = own_flat[r*NUM_RES + b];
        end
        p_single_holder_r3: assert property (@(posedge clk) disable iff (rst)
            $onehot0(col));
    end

    p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (own_flat == '0 && !flag_q && !irq_o));

    p_give_clears_r4: assert property (@(posedge clk) disable iff (rst)
        wr_give |=> ((row_of(own_flat, $past(idx)) & $past(wr_data_i)) == '0));

    p_take_misuse_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_take && |(row_of(own_flat, idx) & wr_data_i)) |=> flag_q);

    p_give_misuse_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_give && |(~row_of(own_flat, idx) & wr_data_i)) |=> flag_q);

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !fl_clr) |=> flag_q);

    p_hole_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && !map_hit) |=> (rd_data_o == '0));
endmodule

bind res_lock_bank lb_checker #(
    .NUM_REQ(NUM_REQ), .NUM_RES(NUM_RES), .IDX_W(lb_pkg::LB_IDX_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .own_flat (own_flat),
    .wr_take  (wr_take),
    .wr_give  (wr_give),
    .fl_clr   (fl_clr),
    .rd_en_i  (rd_en_i),
    .map_hit  (map_hit),
    .idx      (dec.idx),
    .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o),
    .flag_q   (flag_q),
    .irq_o    (irq_o)
);

// File: tb/sim_res_lock_bank.sv
`timescale 1ns/1ps
module sim_res_lock_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit live = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    logic [31:0] m_own [16];
    bit          m_flag = 1'b0, m_en = 1'b0;

    always #4 clk = ~clk;

    res_lock_bank u0 (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
    );

    function automatic int base_of(int i);
        return (i < 6) ? 'h100 + 8*i : 'h200 + 8*(i-6);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // model update for one write
    task automatic model_write(logic [15:0] a, logic [31:0] d);
        bit err = 1'b0;
        for (int i = 0; i < 16; i++) begin
            logic [31:0] oth = '0;
            for (int j = 0; j < 16; j++) if (j != i) oth |= m_own[j];
            if (int'(a) == base_of(i) + 4) begin
                if ((d & m_own[i]) != 0) err = 1'b1;
                m_own[i] = m_own[i] | (d & ~oth);
            end else if (int'(a) == base_of(i)) begin
                if ((d & ~m_own[i]) != 0) err = 1'b1;
                m_own[i] = m_own[i] & ~d;
            end
        end
        if (err) m_flag = 1'b1;
        else if (a == 16'h300 && d[0]) m_flag = 1'b0;
        if (a == 16'h304) m_en = d[0];
    endtask

    function automatic logic [31:0] model_read(logic [15:0] a);
        logic [31:0] r = '0;
        for (int i = 0; i < 16; i++)
            if (int'(a) == base_of(i) || int'(a) == base_of(i) + 4) r = m_own[i];
        if (a == 16'h300) r = {31'b0, m_flag};
        if (a == 16'h304) r = {31'b0, m_en};
        return r;
    endfunction

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(string tag, logic [15:0] a);
        logic [31:0] exp;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp = model_read(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rdata, exp);
    endtask

    // R8: interrupt line compared against the model on every clock
    always @(negedge clk) begin
        if (live) begin
            n_cmp++;
            if (irq !== (m_flag & m_en)) begin
                n_bad++;
                $display("FAIL R8 irq: actual %b expected %b", irq, m_flag & m_en);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_own[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        live = 1'b1;

        // R1 reset state
        rd("R1 req0", 16'h104);
        rd("R1 req15", 16'h248);
        rd("R1 flag", 16'h300);
        rd("R1 enable", 16'h304);

        // R2 free grant; R5 both words read the same
        wr(16'h104, 32'h0000_00F0);
        rd("R2 req0 take", 16'h104);
        rd("R5 req0 give word", 16'h100);
        check("R2 direct", model_read(16'h100), 32'h0000_00F0);

        // R3 blocked bits
        wr(16'h204 + 16'h8, 32'h0000_0FF0);   // req7 take word
        rd("R3 req7 partial", 16'h208);
        rd("R3 holder kept", 16'h100);
        rd("R3 no misuse", 16'h300);
        check("R3 direct", model_read(16'h208), 32'h0000_0F00);

        // R4 give
        wr(16'h100, 32'h0000_0030);
        rd("R4 req0 after give", 16'h104);
        check("R4 direct", model_read(16'h104), 32'h0000_00C0);

        // R6 take of owned bit, grantable bit still granted
        wr(16'h104, 32'h0001_0040);
        rd("R6 flag", 16'h300);
        rd("R6 req0 still granted", 16'h104);
        wr(16'h304, 32'h1);
        rd("R8 enable", 16'h304);
        wr(16'h300, 32'h0);
        rd("R8 flag sticky", 16'h300);
        wr(16'h300, 32'h1);
        rd("R8 flag cleared", 16'h300);

        // R7 give of unowned bit
        wr(16'h208, 32'h0000_1100);
        rd("R7 flag", 16'h300);
        rd("R7 req7", 16'h208);
        wr(16'h300, 32'h1);

        // R9 window edges
        wr(16'h12C, 32'h8000_0000);
        wr(16'h204, 32'h4000_0000);
        wr(16'h24C, 32'h2000_0000);
        rd("R9 req5", 16'h128);
        rd("R9 req6", 16'h200);
        rd("R9 req15", 16'h248);

        // R10 holes
        wr(16'h180, 32'hFFFF_FFFF);
        wr(16'h250, 32'hFFFF_FFFF);
        rd("R10 hole read", 16'h180);
        rd("R10 hole read hi", 16'h254);
        rd("R10 req0 untouched", 16'h100);
        rd("R10 flag untouched", 16'h300);

        // R11 back-to-back contention on bit 20
        wr(16'h11C, 32'h0010_0000);
        wr(16'h124, 32'h0010_0000);
        rd("R11 first wins", 16'h118);
        rd("R11 second loses", 16'h120);
        check("R11 direct", model_read(16'h120) & 32'h0010_0000, 32'h0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule